// File: doc/BRIEF.md
# Time-Shared Sum of Two Products

This block forms the signed sum of two products, `op_a*op_b + op_c*op_d`, with a single multiplier used twice. A one-bit phase register steps the work through two clock cycles. In the first cycle the multiplier sees `op_a` and `op_b`, and its product is kept in a partial-product register. In the second cycle the multiplier sees `op_c` and `op_d`, and that product is added to the kept one. The sum is then registered on the output.

A caller raises `start` with all four operands stable and holds the operands for both cycles. While `start` stays low the block waits in its first phase and does nothing. With `start` held high it accepts a new operand set every two cycles and gives a result every two cycles, which is half the rate of a design with two multipliers. Operands, products and the sum all share one signed width. Every intermediate value is cut to that width, so overflow wraps in two's complement.

Top module: `shared_mult_sum`

## Requirements
- R1: After synchronous reset, `sum_out` is 0 and `sum_valid` is 0. The phase is the first (load) phase and the partial product is 0.
- R2: When `start` is 1 in the load phase, the low `OP_W` bits of `op_a*op_b` are stored as the partial product, and the phase moves to the finish phase on the same edge.
- R3: On the edge that leaves the finish phase, `sum_out` takes the low `OP_W` bits of partial + `op_c*op_d`, read as signed. `sum_valid` is 1 in the cycle after that edge, so the result appears two edges after `start` is taken.
- R4: `sum_valid` is a one-cycle pulse. It is never high in two consecutive cycles.
- R5: `sum_out` changes only on the edge that raises `sum_valid`. At all other times it keeps its last value.
- R6: While `start` is 0 in the load phase, the block stays in the load phase, `sum_valid` stays 0 and `sum_out` does not change.
- R7: `start` has no effect in the finish phase. A started operation completes even if `start` falls, and holding `start` high causes no extra capture.
- R8: With `start` held high and operands changed every two cycles, results come out back to back, one every two cycles.
- R9: Overflow of a product or of the sum wraps to `OP_W` bits in two's complement. Both the default width of 32 and a width of 4 are supported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a two-cycle operation when in the load phase |
| op_a | input | OP_W | First factor of the first product (signed) |
| op_b | input | OP_W | Second factor of the first product (signed) |
| op_c | input | OP_W | First factor of the second product (signed) |
| op_d | input | OP_W | Second factor of the second product (signed) |
| sum_out | output | OP_W | Registered signed sum, truncated |
| sum_valid | output | 1 | One-cycle pulse when a new sum is on `sum_out` |

## Verification
The case hardest to reach from the ports is the phase boundary under continuous demand. With `start` held high, the load-phase capture of a new operand set falls on the same cycle in which the previous result becomes visible. An error in phase steering would mix operands from neighbouring sets. The stimulus runs bursts of operand sets with no idle gap, lets `start` drop inside the finish phase, and uses extreme values such as the most negative number squared. This makes wrap-around in both the product and the sum visible. The same sequences drive a 4-bit instance, where almost every set overflows.

// File: rtl/shared_mult_sum_pkg.sv
package shared_mult_sum_pkg;

    // Two-step schedule: load captures first product, finish forms the sum.
    typedef enum logic {
        PH_LOAD   = 1'b0,
        PH_FINISH = 1'b1
    } phase_e;

    // Per-cycle actions decoded from the phase.
    typedef struct packed {
        logic capture;   // store first product into partial register
        logic finish;    // add second product and register the sum
    } step_t;

    // One-bit phase counter: advances from load only on go, always
    // returns from finish (count 2 wraps to 0).
    function automatic phase_e phase_after(phase_e cur, logic go);
        phase_e nxt;
        case (cur)
            PH_LOAD:   nxt = go ? PH_FINISH : PH_LOAD;
            PH_FINISH: nxt = PH_LOAD;
            default:   nxt = PH_LOAD;
        endcase
        return nxt;
    endfunction

    function automatic step_t decode_step(phase_e cur, logic go);
        step_t s;
        s.capture = (cur == PH_LOAD) && go;
        s.finish  = (cur == PH_FINISH);
        return s;
    endfunction

endpackage

// File: rtl/sms_phase_ctrl.sv
module sms_phase_ctrl
    import shared_mult_sum_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_e phase,
    output step_t  step
);

    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_LOAD;
        end else begin
            phase_q <= phase_after(phase_q, start);
        end
    end

    assign phase = phase_q;
    assign step  = decode_step(phase_q, start);

    // R6: idle in the load phase without a start
    p_idle_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LOAD && !start) |=> (phase_q == PH_LOAD));

    // R2: a taken start moves to the finish phase
    p_start_advances_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LOAD && start) |=> (phase_q == PH_FINISH));

    // R7: finish phase always returns to load, whatever start does
    p_finish_returns_r7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FINISH) |=> (phase_q == PH_LOAD));

endmodule

// File: rtl/sms_operand_steer.sv
module sms_operand_steer
    import shared_mult_sum_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  phase_e                 phase,
    input  logic signed [OP_W-1:0] op_a,
    input  logic signed [OP_W-1:0] op_b,
    input  logic signed [OP_W-1:0] op_c,
    input  logic signed [OP_W-1:0] op_d,
    output logic signed [OP_W-1:0] mul_x,
    output logic signed [OP_W-1:0] mul_y
);

    // Input multiplexers in front of the single multiplier.
    always_comb begin
        if (phase == PH_FINISH) begin
            mul_x = op_c;
            mul_y = op_d;
        end else begin
            mul_x = op_a;
            mul_y = op_b;
        end
    end

endmodule

// File: rtl/sms_shared_mult.sv
module sms_shared_mult #(
    parameter int OP_W = 32
) (
    input  logic signed [OP_W-1:0] mul_x,
    input  logic signed [OP_W-1:0] mul_y,
    output logic signed [OP_W-1:0] prod
);

    // Low OP_W bits of a product do not depend on signedness, so the
    // truncated product is computed directly at operand width.
    always_comb begin
        prod = mul_x * mul_y;
    end

endmodule

// File: rtl/sms_accum_regs.sv
module sms_accum_regs
    import shared_mult_sum_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  step_t                  step,
    input  logic signed [OP_W-1:0] prod,
    output logic signed [OP_W-1:0] sum_q,
    output logic                   valid_q
);

    logic signed [OP_W-1:0] partial_q;
    logic signed [OP_W-1:0] sum_next;

    assign sum_next = partial_q + prod;   // wraps at OP_W bits

    always_ff @(posedge clk) begin
        if (rst) begin
            partial_q <= '0;
            sum_q     <= '0;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= step.finish;
            if (step.capture) begin
                partial_q <= prod;
            end
            if (step.finish) begin
                sum_q <= sum_next;
            end
        end
    end

    // R3: a finish step produces a valid result next cycle
    p_finish_gives_valid_r3: assert property (@(posedge clk) disable iff (rst)
        step.finish |=> valid_q);

    // R4: valid never lasts two cycles
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R5: without a finish step the output register holds
    p_sum_holds_r5: assert property (@(posedge clk) disable iff (rst)
        !step.finish |=> $stable(sum_q));

    // R2: capture and finish never coincide
    p_single_use_r2: assert property (@(posedge clk) disable iff (rst)
        !(step.capture && step.finish));

endmodule

// File: rtl/shared_mult_sum.sv
module shared_mult_sum
    import shared_mult_sum_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic signed [OP_W-1:0] op_a,
    input  logic signed [OP_W-1:0] op_b,
    input  logic signed [OP_W-1:0] op_c,
    input  logic signed [OP_W-1:0] op_d,
    output logic signed [OP_W-1:0] sum_out,
    output logic                   sum_valid
);

    phase_e                 phase;
    step_t                  step;
    logic signed [OP_W-1:0] mul_x;
    logic signed [OP_W-1:0] mul_y;
    logic signed [OP_W-1:0] prod;

    sms_phase_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .phase (phase),
        .step  (step)
    );

    sms_operand_steer #(.OP_W(OP_W)) u_steer (
        .phase (phase),
        .op_a  (op_a),
        .op_b  (op_b),
        .op_c  (op_c),
        .op_d  (op_d),
        .mul_x (mul_x),
        .mul_y (mul_y)
    );

    sms_shared_mult #(.OP_W(OP_W)) u_mult (
        .mul_x (mul_x),
        .mul_y (mul_y),
        .prod  (prod)
    );

    sms_accum_regs #(.OP_W(OP_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .prod    (prod),
        .sum_q   (sum_out),
        .valid_q (sum_valid)
    );

    // R3: a result appears only right after a finish phase
    p_valid_after_finish_r3: assert property (@(posedge clk) disable iff (rst)
        sum_valid |-> $past(phase == PH_FINISH));

endmodule

// File: tb/test_shared_mult_sum.sv
module test_shared_mult_sum;

    localparam int CLK_PERIOD = 10;
    localparam int WW = 32;
    localparam int NW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic signed [WW-1:0] a, b, c, d;
    logic signed [NW-1:0] na, nb, nc, nd;
    logic signed [WW-1:0] sum_w;
    logic signed [NW-1:0] sum_n;
    logic valid_w, valid_n;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int valid_cnt = 0;
    bit done = 1'b0;
    longint q_w[$];
    longint q_n[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    shared_mult_sum #(.OP_W(WW)) i_shared_mult_sum (
        .clk(clk), .rst(rst), .start(start),
        .op_a(a), .op_b(b), .op_c(c), .op_d(d),
        .sum_out(sum_w), .sum_valid(valid_w)
    );

    shared_mult_sum #(.OP_W(NW)) i_shared_mult_sum_w4 (
        .clk(clk), .rst(rst), .start(start),
        .op_a(na), .op_b(nb), .op_c(nc), .op_d(nd),
        .sum_out(sum_n), .sum_valid(valid_n)
    );

    function automatic longint model(int w, longint p, longint q, longint r, longint s);
        longint t;
        t = p * q + r * s;
        t = (t <<< (64 - w)) >>> (64 - w);
        return t;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one operand set, start dropped in the finish phase if keep=0.
    task automatic send(longint p, longint q, longint r, longint s, bit keep);
        a = WW'(p); b = WW'(q); c = WW'(r); d = WW'(s);
        na = NW'(p); nb = NW'(q); nc = NW'(r); nd = NW'(s);
        start = 1'b1;
        @(negedge clk);
        start = keep;
        q_w.push_back(model(WW, longint'(a), longint'(b), longint'(c), longint'(d)));
        q_n.push_back(model(NW, longint'(na), longint'(nb), longint'(nc), longint'(nd)));
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor / scoreboard
    logic signed [WW-1:0] prev_w = '0;
    logic signed [NW-1:0] prev_n = '0;
    logic prev_v = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (valid_w) begin
                valid_cnt++;
                if (q_w.size() == 0) begin
                    check(1'b0, "R3 unexpected valid", longint'(sum_w), 0);
                end else begin
                    longint e;
                    e = q_w.pop_front();
                    check(longint'(sum_w) == e, "R3/R9 sum w32", longint'(sum_w), e);
                end
            end else begin
                check(sum_w == prev_w, "R5 hold w32", longint'(sum_w), longint'(prev_w));
            end
            if (valid_n) begin
                if (q_n.size() == 0) begin
                    check(1'b0, "R9 unexpected valid w4", longint'(sum_n), 0);
                end else begin
                    longint e;
                    e = q_n.pop_front();
                    check(longint'(sum_n) == e, "R9 sum w4", longint'(sum_n), e);
                end
            end
            check(!(prev_v && valid_w), "R4 pulse", longint'(valid_w), 0);
            check(valid_w == valid_n, "R9 widths in step", longint'(valid_n), longint'(valid_w));
        end
        prev_w = sum_w;
        prev_n = sum_n;
        prev_v = valid_w;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c0, y0;
        longint x;
        a = '0; b = '0; c = '0; d = '0;
        na = '0; nb = '0; nc = '0; nd = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(sum_w == 0, "R1 sum", longint'(sum_w), 0);
        check(valid_w == 1'b0, "R1 valid", longint'(valid_w), 0);
        check(sum_n == 0, "R1 sum w4", longint'(sum_n), 0);

        // R6 idle with operands moving but start low
        a = 7; b = 9; c = 3; d = 2;
        repeat (6) begin
            @(negedge clk);
            check(valid_w == 1'b0, "R6 idle valid", longint'(valid_w), 0);
            check(sum_w == 0, "R6 idle sum", longint'(sum_w), 0);
            a = a + 1;
        end

        // R2/R3 basic, timing: valid visible two edges after start
        send(3, 5, 7, 11, 1'b0);
        check(valid_w == 1'b1, "R3 valid timing", longint'(valid_w), 1);
        check(sum_w == 92, "R2/R3 3*5+7*11", longint'(sum_w), 92);
        @(negedge clk);
        check(valid_w == 1'b0, "R4 valid drops", longint'(valid_w), 0);
        check(sum_w == 92, "R5 holds", longint'(sum_w), 92);

        // negatives, start dropped in finish phase (R7)
        send(-4, 6, 9, -2, 1'b0);
        check(sum_w == -42, "R7 completes, -4*6+9*-2", longint'(sum_w), -42);
        repeat (3) @(negedge clk);
        check(sum_w == -42, "R6 idle keeps result", longint'(sum_w), -42);

        // R9 wrap cases
        send(64'h7fffffff, 2, 1, 1, 1'b0);
        check(sum_w == -1, "R9 product+sum wrap", longint'(sum_w), -1);
        send(-64'sh80000000, -64'sh80000000, 0, 0, 1'b0);
        check(sum_w == 0, "R9 min squared", longint'(sum_w), 0);
        send(65536, 65536, 1, 5, 1'b0);
        check(sum_w == 5, "R9 2^32 product", longint'(sum_w), 5);
        send(-8, -8, 7, 7, 1'b0);
        check(sum_n == 1, "R9 w4 -8*-8+7*7", longint'(sum_n), 1);

        // R8/R7 burst with start held high across sets
        c0 = valid_cnt;
        y0 = cyc;
        x = 64'h1234_5678_9abc_def1;
        for (int i = 0; i < 8; i++) begin
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
            send(longint'(int'(x)), longint'(int'(x >> 32)),
                 longint'(int'(x >> 16)), longint'(int'(x >> 8)), 1'b1);
            start = 1'b1;
        end
        start = 1'b0;
        check(valid_cnt - c0 == 8, "R8 burst count", valid_cnt - c0, 8);
        check(cyc - y0 == 16, "R8 burst cycles", cyc - y0, 16);

        repeat (4) @(negedge clk);
        check(q_w.size() == 0, "R3 all results seen", q_w.size(), 0);
        check(q_n.size() == 0, "R9 all w4 results seen", q_n.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule